// File: doc/BRIEF.md
# Programmable Clock Divider Channel with Exact 50% Duty

This block is one output channel of a clock distribution path. It divides a fast input clock by an integer ratio from 1 to 1023. The high and low phases of the result are equal for both even and odd ratios. For odd ratios the extra half input period is produced by a flop clocked on the falling input edge.

After reset the channel stays idle and silent until a synchronization pulse arrives. This lets several channels start counting from the same input edge. Channels with equal ratios that share the same sync pulse therefore run in phase.

The output enable is taken up only in the last input cycle of a period, while the divided clock is low. The polarity select inverts the final output.

Top module: `clkdiv_chan`

## Requirements
- R1: The ratio port is a 10-bit unsigned value. While the channel runs, each output period spans exactly N input cycles, where N is the ratio. A ratio of 0 is treated as 1.
- R2: Each output period starts on a rising input edge. The divided clock is high for exactly N input half-periods and then low for the remaining N half-periods, for both even and odd N.
- R3: After reset, the output stays at its inactive level (equal to inv_i) for as long as no sync has been sampled, whatever the state of en_i.
- R4: A rising input edge that samples sync_i high loads the newly presented ratio and places the channel in the last cycle of a period. For N of 2 or more the output is inactive in that cycle. The first active edge follows on the first rising input edge that samples sync_i low. Holding sync_i high keeps the channel in that state.
- R5: A new ratio is taken up only at the end of a period or on a sync, never in the middle of a period.
- R6: A change of en_i takes effect only on a falling input edge in the last cycle of a period, or at any falling edge while the channel is idle. A disabled channel drives its inactive level, so every high and low phase on the output has full length.
- R7: The output equals inv_i XOR the gated divided clock, so inv_i = 1 inverts the output.
- R8: With N = 1 the output is the input clock itself, gated by the enable and by the running state.
- R9: Two channels that have the same ratio, share the same sync and switch their enables within the same period produce identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 10 | Divide ratio N (0 is treated as 1) |
| sync_i | input | 1 | Synchronization request, sampled on the rising edge |
| en_i | input | 1 | Output enable, sampled on a falling edge at a period boundary |
| inv_i | input | 1 | Output polarity invert |
| clk_o | output | 1 | Divided, gated, polarity-adjusted clock |

## Verification
The assertions assume that all inputs change only between clock edges. They also assume that inv_i is a static setting, since it acts on the output at once. The stimulus meets both conditions by driving every input a few nanoseconds after a rising edge. It changes ratio, enable and polarity at arbitrary points in a period, issues syncs both from idle and mid-period, and holds sync high for several cycles. A behavioural model tracks the position within the period in half-cycles. The output is compared against this model in every half of every input cycle, and a second instance of the channel covers the lock-step requirement.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned RATIO_W_DEF = 10;

  typedef struct packed {
    logic run;
    logic last;
  } cnt_flags_t;
endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = RATIO_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               sync_i,
  output logic [RATIO_W-1:0] cnt_q_o,
  output logic [RATIO_W-1:0] ratio_q_o,
  output logic [RATIO_W-1:0] cnt_d_o,
  output logic [RATIO_W-1:0] ratio_d_o,
  output logic               run_d_o,
  output cnt_flags_t         flags_o
);
  localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

  logic [RATIO_W-1:0] cnt_q, ratio_q, cnt_d, ratio_d, ratio_eff;
  logic               run_q, run_d, last;

  assign ratio_eff = (ratio_i == '0) ? ONE : ratio_i;
  assign last      = (cnt_q == ratio_q - ONE);

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    run_d   = run_q;
    if (sync_i) begin
      // park in terminal cycle; count restarts on release
      run_d   = 1'b1;
      ratio_d = ratio_eff;
      cnt_d   = ratio_eff - ONE;
    end else if (run_q) begin
      if (last) begin
        cnt_d   = '0;
        ratio_d = ratio_eff;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= ONE;
      run_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      run_q   <= run_d;
    end
  end

  assign cnt_q_o    = cnt_q;
  assign ratio_q_o  = ratio_q;
  assign cnt_d_o    = cnt_d;
  assign ratio_d_o  = ratio_d;
  assign run_d_o    = run_d;
  assign flags_o.run  = run_q;
  assign flags_o.last = last;
endmodule

// File: rtl/clkdiv_shaper.sv
module clkdiv_shaper
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = RATIO_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_d_i,
  input  logic [RATIO_W-1:0] cnt_d_i,
  input  logic [RATIO_W-1:0] ratio_d_i,
  output logic               div_o
);
  localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

  logic [RATIO_W-1:0] half;
  logic               hi_q, ext_q, hi_n;

  assign half = ratio_d_i >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      hi_q  <= run_d_i && (cnt_d_i < half);
      // odd ratio: cycle floor(N/2) keeps its first half high
      ext_q <= run_d_i && ratio_d_i[0] && (ratio_d_i != ONE) && (cnt_d_i == half);
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_n <= 1'b0;
    else         hi_n <= hi_q;
  end

  assign div_o = hi_q | (ext_q & hi_n);
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = RATIO_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               inv_i,
  input  cnt_flags_t         flags_i,
  input  logic [RATIO_W-1:0] ratio_q_i,
  input  logic               div_i,
  output logic               gate_o,
  output logic               clk_o
);
  localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

  logic gate_q, bypass, sel;

  // enable moves only in the low half of the terminal cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           gate_q <= 1'b0;
    else if (!flags_i.run || flags_i.last) gate_q <= en_i & flags_i.run;
  end

  assign bypass = (ratio_q_i == ONE);
  assign sel    = bypass ? clk_i : div_i;
  assign clk_o  = inv_i ^ (sel & gate_q);
  assign gate_o = gate_q;
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = RATIO_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               sync_i,
  input  logic               en_i,
  input  logic               inv_i,
  output logic               clk_o
);
  logic [RATIO_W-1:0] cnt_q, ratio_q, cnt_d, ratio_d;
  logic               run_d, run_q, cnt_last, div_raw, gate_q;
  cnt_flags_t         flags;

  clkdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ratio_i  (ratio_i),
    .sync_i   (sync_i),
    .cnt_q_o  (cnt_q),
    .ratio_q_o(ratio_q),
    .cnt_d_o  (cnt_d),
    .ratio_d_o(ratio_d),
    .run_d_o  (run_d),
    .flags_o  (flags)
  );

  clkdiv_shaper #(.RATIO_W(RATIO_W)) u_shp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_d_i  (run_d),
    .cnt_d_i  (cnt_d),
    .ratio_d_i(ratio_d),
    .div_o    (div_raw)
  );

  clkdiv_gate #(.RATIO_W(RATIO_W)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .inv_i    (inv_i),
    .flags_i  (flags),
    .ratio_q_i(ratio_q),
    .div_i    (div_raw),
    .gate_o   (gate_q),
    .clk_o    (clk_o)
  );

  assign run_q    = flags.run;
  assign cnt_last = flags.last;
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int unsigned RATIO_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_i,
  input logic               inv_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               clk_o,
  input logic [RATIO_W-1:0] cnt_q,
  input logic [RATIO_W-1:0] ratio_q,
  input logic               cnt_last,
  input logic               run_q,
  input logic               div_raw,
  input logic               gate_q
);
  logic seen_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_sync <= 1'b0;
    else if (sync_i) seen_sync <= 1'b1;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);

  // R3
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_sync |-> clk_o == inv_i);

  // R4
  sync_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && ratio_i > 1) |=> clk_o == inv_i);

  // R5
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_q) |-> ($past(sync_i) || $past(cnt_last)));

  // R6
  gate_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> ((cnt_last && !div_raw) || !run_q));
endmodule

bind clkdiv_chan clkdiv_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_i  (sync_i),
  .inv_i   (inv_i),
  .ratio_i (ratio_i),
  .clk_o   (clk_o),
  .cnt_q   (cnt_q),
  .ratio_q (ratio_q),
  .cnt_last(cnt_last),
  .run_q   (run_q),
  .div_raw (div_raw),
  .gate_q  (gate_q)
);

// File: tb/clkdiv_chan_tb.sv
module clkdiv_chan_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0, rst_n = 1'b0, sync = 1'b0;
  logic         en = 1'b0, peer_en = 1'b0, inv = 1'b0;
  logic [W-1:0] ratio = 10'd4;
  logic         out, peer_out;

  int    errors = 0, checks = 0;
  string cur_req = "R3";
  bit    done = 1'b0;

  // behavioural model: position in period, ratio, running, gate
  int m_n = 1, m_p = 0;
  bit m_run = 1'b0, m_gate = 1'b0;

  always #10 clk = ~clk;

  clkdiv_chan #(.RATIO_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .sync_i(sync),
    .en_i(en), .inv_i(inv), .clk_o(out)
  );

  clkdiv_chan #(.RATIO_W(W)) peer_i (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .sync_i(sync),
    .en_i(peer_en), .inv_i(inv), .clk_o(peer_out)
  );

  function automatic int eff(int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 1'b0; m_n = 1; m_p = 0;
    end else if (sync) begin
      m_run = 1'b1; m_n = eff(int'(ratio)); m_p = m_n - 1;
    end else if (m_run) begin
      if (m_p == m_n - 1) begin
        m_p = 0; m_n = eff(int'(ratio));
      end else begin
        m_p++;
      end
    end
    #5;
    if (!done) begin
      // high half: half-cycle index 2p is inside the first N halves
      chk(cur_req, out, inv ^ (m_run && m_gate && (2 * m_p < m_n)));
      chk("R9", peer_out, out);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) m_gate = 1'b0;
    else if (!m_run || m_p == m_n - 1) m_gate = en && m_run;
    #5;
    if (!done) begin
      chk(cur_req, out, inv ^ (m_run && m_gate && (2 * m_p + 1 < m_n)));
      chk("R9", peer_out, out);
    end
  end

  task automatic set_en(logic v);
    en = v; peer_en = v;
  endtask

  initial begin
    set_en(1'b1);
    #15;
    chk("R3", out, inv);   // reset state
    #30 rst_n = 1'b1;
    step(20);              // enabled, no sync: stays idle (R3)

    cur_req = "R4"; sync = 1'b1; step(1); sync = 1'b0; step(8);
    cur_req = "R2"; step(20);
    ratio = 10'd5; step(30);
    ratio = 10'd3; step(20);
    ratio = 10'd2; step(12);
    ratio = 10'd11; step(40);

    cur_req = "R5"; ratio = 10'd7; step(3); ratio = 10'd6; step(30);
    ratio = 10'd9; step(2); ratio = 10'd4; step(25);

    cur_req = "R8"; ratio = 10'd1; step(20);
    cur_req = "R7"; inv = 1'b1; step(15);
    ratio = 10'd5; step(20); inv = 1'b0; step(5);

    cur_req = "R1"; ratio = 10'd0; step(12);

    cur_req = "R6"; ratio = 10'd6; step(20);
    for (int i = 0; i < 12; i++) begin
      set_en(~en);
      step(3 + i);
    end
    set_en(1'b1); ratio = 10'd1; step(5);
    for (int i = 0; i < 6; i++) begin
      set_en(~en);
      step(1 + i);
    end
    set_en(1'b1); ratio = 10'd7; step(25);

    cur_req = "R4"; ratio = 10'd9; step(4);
    sync = 1'b1; step(3); sync = 1'b0; step(30);
    ratio = 10'd1; sync = 1'b1; step(2); sync = 1'b0; step(10);

    cur_req = "R9"; ratio = 10'd8; step(20);
    while (m_p != 2) step(1);
    en = 1'b0; step(3); peer_en = 1'b0; step(20);
    while (m_p != 1) step(1);
    peer_en = 1'b1; step(4); en = 1'b1; step(20);

    cur_req = "R1"; ratio = 10'd1023; step(2200);
    ratio = 10'd2; step(1050);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL all: watchdog expired, got hang expected completion");
      summary();
      $finish;
    end
  end
endmodule